// File: doc/BRIEF.md
# SPI Bridge Command Parser

This block is the SPI-slave front end of an SPI-to-I2C bridge. It runs entirely in the system clock domain and oversamples the SPI pins, using SPI mode 0 only: the slave samples on the rising SCLK edge and changes MISO on the falling edge. While chip select is low it assembles bytes and reads the first byte of each frame as an opcode.

I2C transaction opcodes collect a byte count or counts and one or two slave addresses. Write payload bytes are streamed to the sequencer as they arrive, tagged with their group. Once the last byte of a frame is in, the block presents a one-cycle descriptor. Other opcodes do the following:
- Two opcodes give single-register access to a small bank of writable configuration registers and read-only status inputs.
- One opcode streams the sequencer's receive buffer back on MISO.
- One opcode selects MSB-first or LSB-first bit order for all later SPI bytes, in both directions.

The block assumes the SCLK half-period is at least four system clock cycles. Deasserting chip select always returns the parser to the opcode phase.

Top module: `spi_bridge_cmd_parser`

## Requirements
- R1: After reset, MISO is 1 while chip select is deasserted, `lsb_first` is 0, all configuration registers read 0x00, and no descriptor is issued.
- R2: Opcode 0x18 followed by 0x81 selects LSB-first order, and followed by 0x42 selects MSB-first. Any other configuration byte leaves the order unchanged.
- R3: The selected bit order applies to every byte received on MOSI and every byte sent on MISO, starting with the byte after the configuration byte.
- R4: Frame 0x20, addr, data writes data into configuration register addr (addresses 0 to NUM_CFG-1). Exactly one register changes, with no address increment for extra bytes. Writes to status or unmapped addresses change nothing.
- R5: Frame 0x21, addr, dummy returns the register value on MISO during the dummy byte. Addresses 0 to NUM_CFG-1 are configuration registers, the next NUM_STAT addresses are status bytes (`stat_regs` byte i at address NUM_CFG+i), and any other address returns 0xFF.
- R6: Frame 0x01, count, slave address issues one descriptor with kind 0, `desc_addr1` equal to address bits [7:1] (bit 0 ignored), and `desc_len1` equal to count. `desc_valid` lasts one cycle.
- R7: Frame 0x02, nw, nr, addrW, nw data bytes, addrR streams the data bytes with `wr_grp`=0. It then issues a descriptor of kind 1 with addr1 = addrW[7:1], addr2 = addrR[7:1], len1 = nw and len2 = nr.
- R8: Frame 0x03, n1, n2, addr1, n1 bytes, addr2, n2 bytes streams the first group with `wr_grp`=0 and the second with `wr_grp`=1. It issues a descriptor of kind 2 after the last byte.
- R9: A count byte of 0 or above MAX_XFER rejects the frame: no descriptor and no write bytes. A count of exactly MAX_XFER is accepted.
- R10: Raising chip select before a frame is complete issues no descriptor, and the next frame is parsed from its opcode.
- R11: Opcode 0x06 returns receive-buffer entries 0, 1, 2, and so on, one per following byte. Positions at or beyond RBUF_DEPTH return 0xFF.
- R12: The first byte of every frame returns 0xFF. An unknown opcode makes every later byte of the frame return 0xFF and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI clock from host (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Host-to-slave data |
| spi_miso | output | 1 | Slave-to-host data |
| lsb_first | output | 1 | Current bit order, 1 = LSB first |
| desc_valid | output | 1 | One-cycle descriptor strobe |
| desc_kind | output | 2 | 0 read, 1 write-then-read, 2 write-then-write |
| desc_addr1 | output | 7 | First slave address |
| desc_addr2 | output | 7 | Second slave address |
| desc_len1 | output | 8 | First byte count |
| desc_len2 | output | 8 | Second byte count |
| wr_valid | output | 1 | Write payload byte strobe |
| wr_grp | output | 1 | Payload group (0 first, 1 second) |
| wr_data | output | 8 | Payload byte |
| rbuf_addr | output | $clog2(RBUF_DEPTH) | Receive-buffer read index |
| rbuf_data | input | 8 | Receive-buffer byte at `rbuf_addr` |
| stat_regs | input | 8*NUM_STAT | Read-only status bytes |
| cfg_regs | output | 8*NUM_CFG | Configuration register contents |

## Verification
The bench builds the parser with MAX_XFER=6, RBUF_DEPTH=8, NUM_CFG=4 and NUM_STAT=2. The small count limit lets short frames reach the boundary between accepted and rejected counts (6 against 7). The 8-entry buffer lets one readback frame run past the end of the buffer into the 0xFF fill. The two status bytes place a read-only address directly after the writable bank, so writes there can be shown to be ignored and reads there to return live inputs.

// File: rtl/spi_bridge_pkg.sv
// Shared constants and types for the SPI bridge command parser.
// Opcode and configuration values are fixed by the host protocol.
package spi_bridge_pkg;
    localparam logic [7:0] OP_I2C_READ  = 8'h01;
    localparam logic [7:0] OP_I2C_WRRD  = 8'h02;
    localparam logic [7:0] OP_I2C_WRWR  = 8'h03;
    localparam logic [7:0] OP_BUF_READ  = 8'h06;
    localparam logic [7:0] OP_SET_ORDER = 8'h18;
    localparam logic [7:0] OP_REG_WRITE = 8'h20;
    localparam logic [7:0] OP_REG_READ  = 8'h21;
    localparam logic [7:0] ORDER_LSB    = 8'h81;
    localparam logic [7:0] ORDER_MSB    = 8'h42;
    localparam logic [7:0] IDLE_BYTE    = 8'hFF;

    typedef enum logic [1:0] {
        KIND_READ = 2'd0,
        KIND_WRRD = 2'd1,
        KIND_WRWR = 2'd2
    } xfer_kind_e;

    typedef enum logic [3:0] {
        ST_OPC, ST_LEN1, ST_LEN2, ST_ADR1, ST_DAT1, ST_ADR2, ST_DAT2,
        ST_RADR, ST_RWDAT, ST_RDUM, ST_CFG, ST_BUF, ST_SKIP
    } parse_state_e;
endpackage

// File: rtl/sbp_byte_link.sv
// Oversampling SPI mode-0 byte link.
// It synchronizes SCLK, CS_n and MOSI, shifts bytes in on rising SCLK and
// shifts bytes out on falling SCLK, in the selected bit order.
// The next transmit byte is loaded at the falling edge that ends a byte.
// Assumes an SCLK half-period of at least four clk cycles.
module sbp_byte_link (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic       lsb_first,
    input  logic [7:0] tx_next,
    output logic       miso,
    output logic       cs_active,
    output logic       rx_valid,
    output logic [7:0] rx_byte
);
    logic [2:0] sclk_p;
    logic [2:0] csn_p;
    logic [1:0] mosi_p;
    logic [2:0] bit_cnt;
    logic [7:0] rx_sh;
    logic [7:0] tx_sh;
    logic       rise;
    logic       fall;

    // Two-stage synchronizers plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_p <= '0;
            csn_p  <= '1;
            mosi_p <= '0;
        end else begin
            sclk_p <= {sclk_p[1:0], sclk};
            csn_p  <= {csn_p[1:0], cs_n};
            mosi_p <= {mosi_p[0], mosi};
        end
    end

    assign rise      = sclk_p[1] & ~sclk_p[2];
    assign fall      = ~sclk_p[1] & sclk_p[2];
    assign cs_active = ~csn_p[1];

    // Bit counter, receive shifter and transmit shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= spi_bridge_pkg::IDLE_BYTE;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (!cs_active) begin
                bit_cnt <= '0;
                tx_sh   <= spi_bridge_pkg::IDLE_BYTE;
            end else if (rise) begin
                rx_sh    <= lsb_first ? {mosi_p[1], rx_sh[7:1]} : {rx_sh[6:0], mosi_p[1]};
                bit_cnt  <= bit_cnt + 3'd1;
                rx_valid <= (bit_cnt == 3'd7);
            end else if (fall) begin
                if (bit_cnt == 3'd0)
                    tx_sh <= tx_next;
                else
                    tx_sh <= lsb_first ? {1'b1, tx_sh[7:1]} : {tx_sh[6:0], 1'b1};
            end
        end
    end

    assign miso    = cs_active ? (lsb_first ? tx_sh[0] : tx_sh[7]) : 1'b1;
    assign rx_byte = rx_sh;
endmodule

// File: rtl/sbp_local_regs.sv
// Local register bank: NUM_CFG writable configuration bytes at addresses
// 0..NUM_CFG-1, then NUM_STAT read-only status bytes. Other addresses read 0xFF.
// Reads are combinational, writes take one clock edge.
module sbp_local_regs #(
    parameter int NUM_CFG  = 4,
    parameter int NUM_STAT = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [7:0]            waddr,
    input  logic [7:0]            wdata,
    input  logic [7:0]            raddr,
    output logic [7:0]            rdata,
    input  logic [8*NUM_STAT-1:0] stat_in,
    output logic [8*NUM_CFG-1:0]  cfg_out
);
    for (genvar gi = 0; gi < NUM_CFG; gi++) begin : g_cfg
        // One configuration byte, written only when its own address matches.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_out[8*gi +: 8] <= 8'h00;
            else if (we && waddr == 8'(gi))
                cfg_out[8*gi +: 8] <= wdata;
        end
    end

    // Read multiplexer over configuration and status addresses.
    always_comb begin
        rdata = spi_bridge_pkg::IDLE_BYTE;
        for (int i = 0; i < NUM_CFG; i++)
            if (raddr == 8'(i)) rdata = cfg_out[8*i +: 8];
        for (int j = 0; j < NUM_STAT; j++)
            if (raddr == 8'(NUM_CFG + j)) rdata = stat_in[8*j +: 8];
    end
endmodule

// File: rtl/sbp_cmd_fsm.sv
// Frame parser. The first byte of each frame is the opcode, and later bytes are
// steered by the parse state. It issues I2C descriptors and payload strobes,
// register accesses, buffer readback and the bit-order setting. It also
// computes the next MISO byte. Assumes rx_valid is a one-cycle strobe.
module sbp_cmd_fsm
    import spi_bridge_pkg::*;
#(
    parameter int MAX_XFER   = 96,
    parameter int RBUF_DEPTH = 96,
    localparam int RB_AW     = $clog2(RBUF_DEPTH),
    localparam int PTR_W     = $clog2(RBUF_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_active,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    output logic [7:0]       tx_next,
    output logic             lsb_first,
    output logic             desc_valid,
    output logic [1:0]       desc_kind,
    output logic [6:0]       desc_addr1,
    output logic [6:0]       desc_addr2,
    output logic [7:0]       desc_len1,
    output logic [7:0]       desc_len2,
    output logic             wr_valid,
    output logic             wr_grp,
    output logic [7:0]       wr_data,
    output logic             reg_we,
    output logic [7:0]       reg_addr,
    output logic [7:0]       reg_rd_addr,
    input  logic [7:0]       reg_rd_data,
    output logic [RB_AW-1:0] rbuf_addr,
    input  logic [7:0]       rbuf_data
);
    parse_state_e state;
    xfer_kind_e   kind;
    logic [7:0]   remain;
    logic [7:0]   rd_hold;
    logic         is_read;
    logic [PTR_W-1:0] ptr;
    logic         take;
    logic         bad_len;

    assign take    = cs_active && rx_valid;
    assign bad_len = (rx_byte == 8'd0) || (rx_byte > 8'(MAX_XFER));

    // Parse state machine and captured frame fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_OPC;
            kind       <= KIND_READ;
            remain     <= '0;
            rd_hold    <= IDLE_BYTE;
            is_read    <= 1'b0;
            ptr        <= '0;
            lsb_first  <= 1'b0;
            desc_valid <= 1'b0;
            desc_addr1 <= '0;
            desc_addr2 <= '0;
            desc_len1  <= '0;
            desc_len2  <= '0;
            reg_addr   <= '0;
        end else if (!cs_active) begin
            state      <= ST_OPC;
            desc_valid <= 1'b0;
        end else begin
            desc_valid <= 1'b0;
            if (take) begin
                unique case (state)
                    ST_OPC: begin
                        unique case (rx_byte)
                            OP_I2C_READ:  begin kind <= KIND_READ; state <= ST_LEN1; end
                            OP_I2C_WRRD:  begin kind <= KIND_WRRD; state <= ST_LEN1; end
                            OP_I2C_WRWR:  begin kind <= KIND_WRWR; state <= ST_LEN1; end
                            OP_BUF_READ:  begin ptr <= '0; state <= ST_BUF; end
                            OP_SET_ORDER: state <= ST_CFG;
                            OP_REG_WRITE: begin is_read <= 1'b0; state <= ST_RADR; end
                            OP_REG_READ:  begin is_read <= 1'b1; state <= ST_RADR; end
                            default:      state <= ST_SKIP;
                        endcase
                    end
                    ST_LEN1: begin
                        desc_len1 <= rx_byte;
                        if (bad_len)                state <= ST_SKIP;
                        else if (kind == KIND_READ) state <= ST_ADR1;
                        else                        state <= ST_LEN2;
                    end
                    ST_LEN2: begin
                        desc_len2 <= rx_byte;
                        state     <= bad_len ? ST_SKIP : ST_ADR1;
                    end
                    ST_ADR1: begin
                        desc_addr1 <= rx_byte[7:1];
                        if (kind == KIND_READ) begin
                            desc_valid <= 1'b1;
                            state      <= ST_SKIP;
                        end else begin
                            remain <= desc_len1;
                            state  <= ST_DAT1;
                        end
                    end
                    ST_DAT1: begin
                        remain <= remain - 8'd1;
                        if (remain == 8'd1) state <= ST_ADR2;
                    end
                    ST_ADR2: begin
                        desc_addr2 <= rx_byte[7:1];
                        if (kind == KIND_WRRD) begin
                            desc_valid <= 1'b1;
                            state      <= ST_SKIP;
                        end else begin
                            remain <= desc_len2;
                            state  <= ST_DAT2;
                        end
                    end
                    ST_DAT2: begin
                        remain <= remain - 8'd1;
                        if (remain == 8'd1) begin
                            desc_valid <= 1'b1;
                            state      <= ST_SKIP;
                        end
                    end
                    ST_RADR: begin
                        reg_addr <= rx_byte;
                        rd_hold  <= reg_rd_data;
                        state    <= is_read ? ST_RDUM : ST_RWDAT;
                    end
                    ST_RWDAT, ST_RDUM: state <= ST_SKIP;
                    ST_CFG: begin
                        if (rx_byte == ORDER_LSB)      lsb_first <= 1'b1;
                        else if (rx_byte == ORDER_MSB) lsb_first <= 1'b0;
                        state <= ST_SKIP;
                    end
                    ST_BUF: if (ptr != PTR_W'(RBUF_DEPTH)) ptr <= ptr + 1'b1;
                    default: state <= ST_SKIP;
                endcase
            end
        end
    end

    // Next byte to present on MISO, given the state after the last byte.
    always_comb begin
        tx_next = IDLE_BYTE;
        if (state == ST_RDUM)
            tx_next = rd_hold;
        else if (state == ST_BUF && ptr < PTR_W'(RBUF_DEPTH))
            tx_next = rbuf_data;
    end

    assign desc_kind   = kind;
    assign wr_valid    = take && (state == ST_DAT1 || state == ST_DAT2);
    assign wr_grp      = (state == ST_DAT2);
    assign wr_data     = rx_byte;
    assign reg_we      = take && (state == ST_RWDAT);
    assign reg_rd_addr = rx_byte;
    assign rbuf_addr   = ptr[RB_AW-1:0];
endmodule

// File: rtl/spi_bridge_cmd_parser.sv
// Top of the SPI bridge command parser. It ties together the byte link, the
// frame parser and the local register bank. Single clock domain, synchronous
// active-low reset. The SPI pins are oversampled and must be slow relative to clk.
module spi_bridge_cmd_parser #(
    parameter int MAX_XFER   = 96,
    parameter int RBUF_DEPTH = 96,
    parameter int NUM_CFG    = 4,
    parameter int NUM_STAT   = 2,
    localparam int RB_AW     = $clog2(RBUF_DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  spi_sclk,
    input  logic                  spi_cs_n,
    input  logic                  spi_mosi,
    output logic                  spi_miso,
    output logic                  lsb_first,
    output logic                  desc_valid,
    output logic [1:0]            desc_kind,
    output logic [6:0]            desc_addr1,
    output logic [6:0]            desc_addr2,
    output logic [7:0]            desc_len1,
    output logic [7:0]            desc_len2,
    output logic                  wr_valid,
    output logic                  wr_grp,
    output logic [7:0]            wr_data,
    output logic [RB_AW-1:0]      rbuf_addr,
    input  logic [7:0]            rbuf_data,
    input  logic [8*NUM_STAT-1:0] stat_regs,
    output logic [8*NUM_CFG-1:0]  cfg_regs
);
    logic       cs_active;
    logic       rx_valid;
    logic [7:0] rx_byte;
    logic [7:0] tx_next;
    logic       reg_we;
    logic [7:0] reg_addr;
    logic [7:0] reg_rd_addr;
    logic [7:0] reg_rd_data;

    sbp_byte_link i_link (
        .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .lsb_first(lsb_first), .tx_next(tx_next), .miso(spi_miso),
        .cs_active(cs_active), .rx_valid(rx_valid), .rx_byte(rx_byte)
    );

    sbp_cmd_fsm #(.MAX_XFER(MAX_XFER), .RBUF_DEPTH(RBUF_DEPTH)) i_fsm (
        .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_next(tx_next), .lsb_first(lsb_first),
        .desc_valid(desc_valid), .desc_kind(desc_kind), .desc_addr1(desc_addr1),
        .desc_addr2(desc_addr2), .desc_len1(desc_len1), .desc_len2(desc_len2),
        .wr_valid(wr_valid), .wr_grp(wr_grp), .wr_data(wr_data),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_rd_addr(reg_rd_addr),
        .reg_rd_data(reg_rd_data), .rbuf_addr(rbuf_addr), .rbuf_data(rbuf_data)
    );

    sbp_local_regs #(.NUM_CFG(NUM_CFG), .NUM_STAT(NUM_STAT)) i_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_addr), .wdata(rx_byte),
        .raddr(reg_rd_addr), .rdata(reg_rd_data), .stat_in(stat_regs),
        .cfg_out(cfg_regs)
    );
endmodule

// File: rtl/sbp_parser_checker.sv
// Temporal checks on the command parser, attached to the top by bind.
module sbp_parser_checker #(
    parameter int NUM_CFG = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 spi_cs_n,
    input logic                 spi_miso,
    input logic                 cs_active,
    input logic                 desc_valid,
    input logic                 wr_valid,
    input logic                 lsb_first,
    input logic [8*NUM_CFG-1:0] cfg_regs
);
    // MISO idles high once chip select has been high for two samples.
    assert_miso_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(spi_cs_n, 2) && $past(spi_cs_n)) |-> spi_miso);

    // Bit order never changes outside a frame.
    assert_order_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> $stable(lsb_first));

    // Configuration registers never change outside a frame.
    assert_cfg_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> $stable(cfg_regs));

    // A descriptor is a one-cycle strobe.
    assert_desc_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |=> !desc_valid);

    // Payload bytes appear only while a frame is open.
    assert_wr_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> cs_active);

    // A descriptor follows only from a cycle inside a frame.
    assert_desc_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> $past(cs_active));
endmodule

bind spi_bridge_cmd_parser sbp_parser_checker #(.NUM_CFG(NUM_CFG)) i_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
    .cs_active(cs_active), .desc_valid(desc_valid), .wr_valid(wr_valid),
    .lsb_first(lsb_first), .cfg_regs(cfg_regs)
);

// File: tb/test_spi_bridge_cmd_parser.sv
// Directed bench: one task per scenario, each checking its own results.
module test_spi_bridge_cmd_parser;
    localparam int MAX_XFER = 6;
    localparam int DEPTH    = 8;
    localparam int NCFG     = 4;
    localparam int NSTAT    = 2;
    localparam int HALF     = 8;

    logic clk = 1'b0;
    logic rst_n, spi_sclk, spi_cs_n, spi_mosi, spi_miso, lsb_first;
    logic desc_valid, wr_valid, wr_grp;
    logic [1:0] desc_kind;
    logic [6:0] desc_addr1, desc_addr2;
    logic [7:0] desc_len1, desc_len2, wr_data, rbuf_data;
    logic [2:0] rbuf_addr;
    logic [8*NSTAT-1:0] stat_regs = 16'h665A;
    logic [8*NCFG-1:0]  cfg_regs;
    logic [7:0] rbuf_mem [0:DEPTH-1];
    logic [7:0] txq [0:15];
    logic [7:0] rxq [0:15];
    logic [8:0] wr_log [0:31];
    int checks = 0, errors = 0, desc_cnt = 0, wr_cnt = 0;
    logic tb_lsb = 1'b0;
    logic [1:0] cap_kind;
    logic [6:0] cap_a1, cap_a2;
    logic [7:0] cap_l1, cap_l2;

    always #5 clk = ~clk;
    assign rbuf_data = rbuf_mem[rbuf_addr];

    spi_bridge_cmd_parser #(.MAX_XFER(MAX_XFER), .RBUF_DEPTH(DEPTH),
                            .NUM_CFG(NCFG), .NUM_STAT(NSTAT)) i_spi_bridge_cmd_parser (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .lsb_first(lsb_first),
        .desc_valid(desc_valid), .desc_kind(desc_kind), .desc_addr1(desc_addr1),
        .desc_addr2(desc_addr2), .desc_len1(desc_len1), .desc_len2(desc_len2),
        .wr_valid(wr_valid), .wr_grp(wr_grp), .wr_data(wr_data),
        .rbuf_addr(rbuf_addr), .rbuf_data(rbuf_data), .stat_regs(stat_regs),
        .cfg_regs(cfg_regs)
    );

    // Record descriptors and payload strobes.
    always @(posedge clk) begin
        if (desc_valid) begin
            desc_cnt <= desc_cnt + 1;
            cap_kind <= desc_kind; cap_a1 <= desc_addr1; cap_a2 <= desc_addr2;
            cap_l1 <= desc_len1; cap_l2 <= desc_len2;
        end
        if (wr_valid) begin
            wr_log[wr_cnt % 32] <= {wr_grp, wr_data};
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // One chip-select frame of n bytes from txq, with the replies in rxq.
    task automatic spi_frame(input int n);
        spi_cs_n = 1'b0;
        repeat (2*HALF) @(negedge clk);
        for (int b = 0; b < n; b++) begin
            for (int k = 0; k < 8; k++) begin
                int idx;
                idx = tb_lsb ? k : 7 - k;
                spi_mosi = txq[b][idx];
                repeat (HALF) @(negedge clk);
                rxq[b][idx] = spi_miso;
                spi_sclk = 1'b1;
                repeat (HALF) @(negedge clk);
                spi_sclk = 1'b0;
            end
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (2*HALF) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 miso idle", 32'(spi_miso), 32'd1);
        chk("R1 order default", 32'(lsb_first), 32'd0);
        chk("R1 cfg reset", cfg_regs, 32'h0);
        chk("R1 no descriptor", desc_cnt, 0);
    endtask

    task automatic t_regs;
        txq[0] = 8'h20; txq[1] = 8'h01; txq[2] = 8'hA5; spi_frame(3);
        chk("R4 single write", cfg_regs, 32'h0000A500);
        chk("R12 first byte FF", 32'(rxq[0]), 32'hFF);
        txq[0] = 8'h20; txq[1] = 8'h02; txq[2] = 8'h3C; txq[3] = 8'h77; spi_frame(4);
        chk("R4 no increment", cfg_regs, 32'h003CA500);
        txq[0] = 8'h20; txq[1] = 8'h04; txq[2] = 8'h99; spi_frame(3);
        chk("R4 status write ignored", cfg_regs, 32'h003CA500);
        txq[0] = 8'h21; txq[1] = 8'h01; txq[2] = 8'h00; spi_frame(3);
        chk("R5 read cfg", 32'(rxq[2]), 32'hA5);
        txq[1] = 8'h04; spi_frame(3);
        chk("R5 read status", 32'(rxq[2]), 32'h5A);
        txq[1] = 8'h30; spi_frame(3);
        chk("R5 read unmapped", 32'(rxq[2]), 32'hFF);
    endtask

    task automatic t_order;
        txq[0] = 8'h18; txq[1] = 8'h81; spi_frame(2);
        chk("R2 select lsb", 32'(lsb_first), 32'd1);
        tb_lsb = 1'b1;
        txq[0] = 8'h21; txq[1] = 8'h01; txq[2] = 8'h00; spi_frame(3);
        chk("R3 lsb readback", 32'(rxq[2]), 32'hA5);
        txq[0] = 8'h20; txq[1] = 8'h00; txq[2] = 8'h12; spi_frame(3);
        chk("R3 lsb write", cfg_regs, 32'h003CA512);
        txq[0] = 8'h18; txq[1] = 8'h55; spi_frame(2);
        chk("R2 other value ignored", 32'(lsb_first), 32'd1);
        txq[0] = 8'h18; txq[1] = 8'h42; spi_frame(2);
        chk("R2 select msb", 32'(lsb_first), 32'd0);
        tb_lsb = 1'b0;
    endtask

    task automatic t_read_desc;
        txq[0] = 8'h01; txq[1] = 8'h05; txq[2] = 8'hA3; spi_frame(3);
        chk("R6 count", desc_cnt, 1);
        chk("R6 fields", {cap_kind, cap_a1, cap_l1}, {2'd0, 7'h51, 8'd5});
        txq[1] = 8'h06; txq[2] = 8'hA2; spi_frame(3);
        chk("R9 max accepted", desc_cnt, 2);
        chk("R6 addr lsb ignored", {cap_a1, cap_l1}, {7'h51, 8'd6});
    endtask

    task automatic t_wrrd;
        txq[0] = 8'h02; txq[1] = 8'h02; txq[2] = 8'h04; txq[3] = 8'h90;
        txq[4] = 8'h11; txq[5] = 8'h22; txq[6] = 8'h91; spi_frame(7);
        chk("R7 count", desc_cnt, 3);
        chk("R7 fields", {cap_kind, cap_a1, cap_a2, cap_l1, cap_l2},
            {2'd1, 7'h48, 7'h48, 8'd2, 8'd4});
        chk("R7 payload", {wr_cnt[7:0], wr_log[0], wr_log[1]}, {8'd2, 9'h011, 9'h022});
    endtask

    task automatic t_wrwr;
        txq[0] = 8'h03; txq[1] = 8'h01; txq[2] = 8'h02; txq[3] = 8'h40;
        txq[4] = 8'hAA; txq[5] = 8'h42; txq[6] = 8'hBB; txq[7] = 8'hCC; spi_frame(8);
        chk("R8 count", desc_cnt, 4);
        chk("R8 fields", {cap_kind, cap_a1, cap_a2, cap_l1, cap_l2},
            {2'd2, 7'h20, 7'h21, 8'd1, 8'd2});
        chk("R8 payload", {wr_cnt[7:0], wr_log[2], wr_log[3], wr_log[4]},
            {8'd5, 9'h0AA, 9'h1BB, 9'h1CC});
    endtask

    task automatic t_bad_count;
        txq[0] = 8'h01; txq[1] = 8'h07; txq[2] = 8'hA3; spi_frame(3);
        chk("R9 over limit", desc_cnt, 4);
        txq[0] = 8'h02; txq[1] = 8'h00; txq[2] = 8'h01; txq[3] = 8'h90;
        txq[4] = 8'h11; txq[5] = 8'h91; spi_frame(6);
        chk("R9 zero count", {desc_cnt[7:0], wr_cnt[7:0]}, {8'd4, 8'd5});
    endtask

    task automatic t_abort;
        txq[0] = 8'h03; txq[1] = 8'h02; txq[2] = 8'h01; txq[3] = 8'h40; txq[4] = 8'hAA;
        spi_frame(5);
        chk("R10 no descriptor", desc_cnt, 4);
        txq[0] = 8'h01; txq[1] = 8'h02; txq[2] = 8'hA0; spi_frame(3);
        chk("R10 restart", {desc_cnt[7:0], cap_a1, cap_l1}, {8'd5, 7'h50, 8'd2});
    endtask

    task automatic t_buffer;
        for (int i = 0; i < DEPTH; i++) rbuf_mem[i] = 8'(8'h10 + i);
        txq[0] = 8'h06;
        for (int i = 1; i < 11; i++) txq[i] = 8'h00;
        spi_frame(11);
        for (int i = 1; i < 11; i++)
            chk("R11 buffer byte", 32'(rxq[i]), (i <= DEPTH) ? 32'(8'h10 + i - 1) : 32'hFF);
    endtask

    task automatic t_unknown;
        txq[0] = 8'h55; txq[1] = 8'h20; txq[2] = 8'h01; txq[3] = 8'h77; spi_frame(4);
        chk("R12 reply", {rxq[0], rxq[1], rxq[2], rxq[3]}, 32'hFFFFFFFF);
        chk("R12 no effect", cfg_regs, 32'h003CA512);
    endtask

    initial begin
        rst_n = 1'b0; spi_cs_n = 1'b1; spi_sclk = 1'b0; spi_mosi = 1'b0;
        for (int i = 0; i < DEPTH; i++) rbuf_mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset;
        t_regs;
        t_order;
        t_read_desc;
        t_wrrd;
        t_wrwr;
        t_bad_count;
        t_abort;
        t_buffer;
        t_unknown;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule